// File: doc/BRIEF.md
# Synchronous Serial Position Reader (Master Side)

This block is the controller end of a point-to-point synchronous serial link of the kind used to poll absolute position sensors. A start request makes it drive a burst of clock pulses on one shared clock output. It samples up to three data inputs in parallel, one per sensor, and assembles each into a right-aligned parallel word. Between bursts the clock rests HIGH. The block keeps the line HIGH for at least a programmable pause before the next burst, so that every sensor sees its monoflop time run out and refreshes its value.

The system logic sets the word length, the half-period of the serial clock in system cycles, and the pause length. It then pulses a start request and waits for a one-cycle done pulse, after which the received words are valid. A request that arrives during the pause is held and launched once the pause has elapsed. An abort input stops the clock at once. The aborted frame delivers no data, and the pause still applies. While idle, a data line must rest HIGH. Any line that is LOW when a frame is launched sets a per-lane fault flag.

Top module: `ssi_frame_master`

## Requirements
- R1: The serial clock output is HIGH after reset, while idle and during the pause; it is LOW only within a burst.
- R2: A start accepted while idle makes the clock fall on the next system clock edge. Each clock half-period lasts `half_div_i` system cycles, with 0 treated as 1. A burst has one leading clock cycle without a sample, then one rising edge per data bit, so the done pulse appears H*(2L+1) cycles after the launching edge, where H is the half-period and L the effective length.
- R3: Data is sampled at the rising clock edges after the leading cycle, most significant bit first. The word is right-aligned with zeros above the received bits. A length of 0 is read as 1, and a length above MAX_BITS is read as MAX_BITS.
- R4: Done is a single-cycle pulse, and the words change only in the cycle where done is raised.
- R5: All NUM_CH lanes are sampled on the same clock edges, and each lane produces its own word from its own data input.
- R6: After a burst ends or is aborted, the clock stays HIGH for at least `gap_len_i` system cycles (0 treated as 1) before the next falling edge.
- R7: A start request during the pause is held, and the next burst launches on exactly the edge where the pause expires, including a request that arrives in the expiry cycle itself. A start request during a burst is ignored.
- R8: An abort during a burst returns the clock HIGH on the next edge, produces no done pulse and leaves the words unchanged. The pause then follows.
- R9: Each lane's fault flag takes the inverse of its data input in the cycle a burst is launched, and holds until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to read one frame |
| abort_i | input | 1 | Stops a running burst |
| word_len_i | input | LEN_W | Bits per frame (1..MAX_BITS) |
| half_div_i | input | DIV_W | System cycles per serial half-period |
| gap_len_i | input | TMO_W | Minimum HIGH pause in system cycles |
| sdat_i | input | NUM_CH | Data input of each sensor |
| sclk_o | output | 1 | Shared serial clock, idles HIGH |
| done_o | output | 1 | One-cycle pulse when words are updated |
| word_o | output | NUM_CH*MAX_BITS | Received words, lane 0 in the low bits |
| fault_o | output | NUM_CH | Lane was LOW at frame launch |

## Verification
Two events can fall in the same cycle: the expiry of the pause and a new start request. The bench drives a request exactly in the last pause cycle. It also drives a request early in the pause, which is then held. In both cases it counts the HIGH cycles between the done pulse and the next falling clock edge and expects exactly the pause length, which shows the request was neither lost nor delayed. The frame that follows is then read and compared against the sensor values of the bench model.

// File: rtl/ssi_master_pkg.sv
package ssi_master_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_BITS  = 2'd2,
      ST_GAP   = 2'd3
   } ssi_state_e;
endpackage

// File: rtl/ssi_period_cnt.sv
module ssi_period_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             end_o
);
   logic [CNT_W-1:0] cnt_q;

   assign end_o = run_i && (cnt_q == limit_i - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || end_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && limit_i != '0) |-> (cnt_q < limit_i)); // R2
endmodule

// File: rtl/ssi_rx_lane.sv
module ssi_rx_lane #(
   parameter int MAX_BITS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm_i,
   input  logic                sample_i,
   input  logic                commit_i,
   input  logic                sdat_i,
   output logic [MAX_BITS-1:0] word_o,
   output logic                fault_o
);
   logic [MAX_BITS-1:0] sh_q;
   logic [MAX_BITS-1:0] sh_next;

   assign sh_next = {sh_q[MAX_BITS-2:0], sdat_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         word_o  <= '0;
         fault_o <= 1'b0;
      end else begin
         if (arm_i) begin
            sh_q    <= '0;
            fault_o <= ~sdat_i;
         end else if (sample_i) begin
            sh_q <= sh_next;
         end
         if (commit_i)
            word_o <= sh_next;
      end
   end

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(word_o)); // R4
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |=> $stable(fault_o)); // R9
endmodule

// File: rtl/ssi_frame_master.sv
module ssi_frame_master
   import ssi_master_pkg::*;
#(
   parameter int MAX_BITS = 32,
   parameter int NUM_CH   = 3,
   parameter int DIV_W    = 8,
   parameter int TMO_W    = 12,
   localparam int LEN_W   = $clog2(MAX_BITS) + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       abort_i,
   input  logic [LEN_W-1:0]           word_len_i,
   input  logic [DIV_W-1:0]           half_div_i,
   input  logic [TMO_W-1:0]           gap_len_i,
   input  logic [NUM_CH-1:0]          sdat_i,
   output logic                       sclk_o,
   output logic                       done_o,
   output logic [NUM_CH*MAX_BITS-1:0] word_o,
   output logic [NUM_CH-1:0]          fault_o
);
   if (MAX_BITS < 2) begin : g_bad_bits
      $error("MAX_BITS must be at least 2");
   end
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("NUM_CH must be 1 to 3");
   end
   if (DIV_W < 1 || TMO_W < 1) begin : g_bad_w
      $error("counter widths must be positive");
   end

   ssi_state_e       state_q;
   logic             sclk_q, done_q, pend_q;
   logic [LEN_W-1:0] bit_q, len_q, len_eff;
   logic [DIV_W-1:0] half_q, half_eff;
   logic [TMO_W-1:0] gap_q, gap_eff;
   logic             busy, tick, gap_end, rise, fall;
   logic             abort_act, sample, last, launch;

   always_comb begin
      if (word_len_i == '0)
         len_eff = LEN_W'(1);
      else if (word_len_i > LEN_W'(MAX_BITS))
         len_eff = LEN_W'(MAX_BITS);
      else
         len_eff = word_len_i;
   end
   assign half_eff = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
   assign gap_eff  = (gap_len_i == '0)  ? TMO_W'(1) : gap_len_i;

   assign busy      = (state_q == ST_LEAD) || (state_q == ST_BITS);
   assign abort_act = busy && abort_i;
   assign rise      = tick && !sclk_q;
   assign fall      = tick && sclk_q;
   assign sample    = (state_q == ST_BITS) && rise && !abort_act;
   assign last      = sample && (bit_q == len_q - LEN_W'(1));
   assign launch    = ((state_q == ST_IDLE) && start_i) ||
                      ((state_q == ST_GAP) && gap_end && (pend_q || start_i));

   ssi_period_cnt #(.CNT_W(DIV_W)) u_half (
      .clk(clk), .rst_n(rst_n), .run_i(busy), .limit_i(half_q), .end_o(tick));

   ssi_period_cnt #(.CNT_W(TMO_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_GAP), .limit_i(gap_q), .end_o(gap_end));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sclk_q  <= 1'b1;
         done_q  <= 1'b0;
         pend_q  <= 1'b0;
         bit_q   <= '0;
         len_q   <= LEN_W'(1);
         half_q  <= DIV_W'(1);
         gap_q   <= TMO_W'(1);
      end else begin
         done_q <= 1'b0;
         if (launch) begin
            state_q <= ST_LEAD;
            sclk_q  <= 1'b0;
            bit_q   <= '0;
            pend_q  <= 1'b0;
            len_q   <= len_eff;
            half_q  <= half_eff;
            gap_q   <= gap_eff;
         end else begin
            case (state_q)
               ST_LEAD: begin
                  if (abort_act) begin
                     state_q <= ST_GAP;
                     sclk_q  <= 1'b1;
                  end else if (tick) begin
                     sclk_q <= ~sclk_q;
                     if (fall) state_q <= ST_BITS;
                  end
               end
               ST_BITS: begin
                  if (abort_act) begin
                     state_q <= ST_GAP;
                     sclk_q  <= 1'b1;
                  end else if (tick) begin
                     sclk_q <= ~sclk_q;
                     if (rise) bit_q <= bit_q + LEN_W'(1);
                     if (last) begin
                        state_q <= ST_GAP;
                        done_q  <= 1'b1;
                     end
                  end
               end
               ST_GAP: begin
                  if (start_i) pend_q <= 1'b1;
                  if (gap_end) state_q <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assign sclk_o = sclk_q;
   assign done_o = done_q;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      ssi_rx_lane #(.MAX_BITS(MAX_BITS)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm_i    (launch),
         .sample_i (sample),
         .commit_i (last),
         .sdat_i   (sdat_i[g]),
         .word_o   (word_o[g*MAX_BITS +: MAX_BITS]),
         .fault_o  (fault_o[g]));
   end

   // Checker state: HIGH-run length of the clock and whether any burst has ended.
   logic [TMO_W-1:0] hi_run_q;
   logic             seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run_q <= '0;
         seen_q   <= 1'b0;
      end else begin
         if (!sclk_q)
            hi_run_q <= '0;
         else if (hi_run_q != '1)
            hi_run_q <= hi_run_q + TMO_W'(1);
         if (state_q == ST_GAP)
            seen_q <= 1'b1;
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE || state_q == ST_GAP) |-> sclk_o); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R4
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      abort_act |=> (sclk_o && !done_o)); // R8
   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sclk_o) && state_q == ST_LEAD && seen_q) |-> (hi_run_q >= $past(gap_q))); // R6
endmodule

// File: tb/test_ssi_frame_master.sv
module test_ssi_frame_master;
   localparam int MB = 32;
   localparam int NC = 3;
   localparam int DW = 8;
   localparam int TW = 12;
   localparam int LW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          start = 1'b0, abort = 1'b0;
   logic [LW-1:0] word_len = 6'd8;
   logic [DW-1:0] half_div = 8'd1;
   logic [TW-1:0] gap_len = 12'd16;
   logic [NC-1:0] sdat, slv_dat = '1, fmask = '0;
   logic          sclk, done;
   logic [NC*MB-1:0] word;
   logic [NC-1:0] fault;

   assign sdat = slv_dat & ~fmask;

   ssi_frame_master #(.MAX_BITS(MB), .NUM_CH(NC), .DIV_W(DW), .TMO_W(TW)) i_ssi_frame_master (
      .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
      .word_len_i(word_len), .half_div_i(half_div), .gap_len_i(gap_len),
      .sdat_i(sdat), .sclk_o(sclk), .done_o(done), .word_o(word), .fault_o(fault));

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   // Sensor model: freezes on first fall, presents MSB after the leading cycle,
   // returns HIGH after 12 HIGH cycles of the clock.
   logic [31:0] slv_val [NC];
   int slv_len = 8;
   logic prev_sclk = 1'b1;
   int kfall = 0, hicnt = 0;
   always @(negedge clk) begin
      if (prev_sclk && !sclk) begin
         kfall = kfall + 1;
         for (int c = 0; c < NC; c++)
            slv_dat[c] = (kfall >= 2 && kfall - 2 < slv_len) ? slv_val[c][slv_len-1-(kfall-2)] : 1'b1;
      end
      if (sclk) hicnt = hicnt + 1; else hicnt = 0;
      if (hicnt >= 12) begin
         kfall = 0;
         slv_dat = '1;
      end
      prev_sclk = sclk;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int eff_len(int l);
      if (l == 0) return 1;
      if (l > MB) return MB;
      return l;
   endfunction

   function automatic logic [31:0] exp_word(logic [31:0] v, int l);
      if (l >= 32) return v;
      return v & ((32'h1 << l) - 32'h1);
   endfunction

   task automatic set_vals();
      for (int c = 0; c < NC; c++) slv_val[c] = $urandom;
   endtask

   task automatic launch(input int len, input int h, input int p, input logic [NC-1:0] fm);
      @(negedge clk);
      word_len = LW'(len); half_div = DW'(h); gap_len = TW'(p);
      slv_len = eff_len(len); fmask = fm; start = 1'b1;
      @(negedge clk);
      start = 1'b0; fmask = '0;
   endtask

   task automatic wait_done(output int n, output int r);
      logic ps;
      ps = sclk; n = 1; r = 0;
      for (int i = 0; i < 5000; i++) begin
         if (!ps && sclk) r++;
         ps = sclk;
         if (done) break;
         @(negedge clk);
         n++;
      end
   endtask

   task automatic check_words(input string tag);
      for (int c = 0; c < NC; c++)
         chk(word[c*MB +: MB] == exp_word(slv_val[c], slv_len), tag,
             word[c*MB +: MB], exp_word(slv_val[c], slv_len));
   endtask

   task automatic gap_probe(input int when, output int hc);
      hc = 1;
      if (when == 1) start = 1'b1;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         start = 1'b0;
         if (!sclk) break;
         hc++;
         if (hc == when) start = 1'b1;
      end
   endtask

   task automatic full_frame(input int len, input int h, input int p, input logic [NC-1:0] fm, input string tag);
      int n, r, he;
      launch(len, h, p, fm);
      wait_done(n, r);
      he = (h == 0) ? 1 : h;
      chk(done == 1'b1, {tag, " R4 done seen"}, done, 1);
      chk(n == he * (2 * eff_len(len) + 1) + 1, {tag, " R2 latency"}, n, he * (2 * eff_len(len) + 1) + 1);
      chk(r == eff_len(len) + 1, {tag, " R2 rising edges"}, r, eff_len(len) + 1);
      check_words({tag, " R3 R5 lane word"});
      @(negedge clk);
      chk(done == 1'b0, {tag, " R4 done width"}, done, 0);
      repeat (p + 14) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int hc, n, r;
      logic [NC*MB-1:0] held;
      void'($urandom(32'h5eed_0042));
      for (int c = 0; c < NC; c++) slv_val[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sclk == 1'b1, "R1 reset clock", sclk, 1);
      chk(done == 1'b0, "R4 reset done", done, 0);
      chk(word == '0, "R4 reset words", word[31:0], 0);
      chk(fault == '0, "R9 reset fault", fault, 0);
      repeat (20) @(negedge clk);
      chk(sclk == 1'b1, "R1 idle clock", sclk, 1);

      // Random frames
      for (int i = 0; i < 30; i++) begin
         set_vals();
         full_frame($urandom_range(1, 32), $urandom_range(1, 4), $urandom_range(16, 40), '0, "rand");
      end

      // R3 R2 clamping of length and divider
      set_vals();
      full_frame(0, 0, 16, '0, "len0");
      set_vals();
      full_frame(40, 1, 16, '0, "len40");
      set_vals();
      full_frame(32, 2, 16, '0, "len32");

      // R6 R7 start held from early in the pause
      set_vals();
      launch(8, 2, 30, '0);
      wait_done(n, r);
      gap_probe(1, hc);
      chk(hc == 30, "R6 R7 held start gap", hc, 30);
      wait_done(n, r);
      chk(n == 2 * 17 + 1, "R7 held frame latency", n, 35);
      check_words("R7 held frame word");
      repeat (50) @(negedge clk);

      // R7 start arriving in the cycle the pause expires
      set_vals();
      launch(12, 1, 25, '0);
      wait_done(n, r);
      gap_probe(25, hc);
      chk(hc == 25, "R6 R7 coincident start gap", hc, 25);
      wait_done(n, r);
      chk(n == 25 + 1, "R7 coincident frame latency", n, 26);
      check_words("R7 coincident frame word");
      repeat (50) @(negedge clk);

      // R7 start during a burst is ignored
      set_vals();
      launch(16, 3, 20, '0);
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(n, r);
      check_words("R7 busy frame word");
      hc = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (!sclk || done) hc++;
      end
      chk(hc == 0, "R7 busy start ignored", hc, 0);

      // R8 abort mid-burst
      held = word;
      set_vals();
      launch(24, 2, 20, '0);
      repeat (15) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(sclk == 1'b1, "R8 clock high after abort", sclk, 1);
      hc = 0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (!sclk || done) hc++;
      end
      chk(hc == 0, "R8 no done after abort", hc, 0);
      chk(word == held, "R8 words kept", word[31:0], held[31:0]);

      // R9 line fault at launch
      set_vals();
      full_frame(10, 2, 20, 3'b010, "fault");
      chk(fault == 3'b010, "R9 fault flags", fault, 3'b010);
      set_vals();
      full_frame(10, 2, 20, 3'b101, "fault2");
      chk(fault == 3'b101, "R9 fault flags two", fault, 3'b101);
      set_vals();
      full_frame(10, 2, 20, '0, "nofault");
      chk(fault == 3'b000, "R9 fault cleared", fault, 0);
      chk(sclk == 1'b1, "R1 clock high at end", sclk, 1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule